// File: doc/BRIEF.md
# Sixteen-Bit Accumulator Instruction Processor

This block is a small stored-program processor built around one 16-bit accumulator (AC) and a one-bit extension flag (E). It holds its program and data in an internal memory of 4096 sixteen-bit words. It steps through each instruction in timed phases: fetch, decode, an optional indirect-address read, and execute. It then repeats until it meets a halt instruction. It has no I/O or interrupt handling.

Memory is filled through a preload port while reset is held. When reset is released, the processor runs from address 0. The halted flag tells the surroundings that the run is over. At that point the debug outputs for AC, PC and E show the final machine state, and this state stays frozen until the next reset.

An instruction word has three fields. Bit 15 is the indirect flag, bits 14:12 are the operation, and bits 11:0 are the address. Operation 7 with bit 15 clear is a register operation. In that case each of the low twelve bits switches one accumulator, flag, skip or halt action on or off.

Top module: `acc_cpu`

## Requirements
- R1: While `rst` is high, AC, E and PC are driven to zero and `halted` is low. A word on `pre_data` is written at `pre_addr` on each clock edge where `pre_we` is high.
- R2: Each instruction is read from the word at PC, and PC then advances by one. Bit 15 is the indirect flag, bits 14:12 the operation and bits 11:0 the address.
- R3: Operation 0 ANDs the operand into AC. Operation 1 adds the operand to AC and puts the carry-out in E. Operation 2 loads the operand into AC.
- R4: Operation 3 writes AC to the effective address.
- R5: Operation 4 jumps: PC becomes the effective address.
- R6: Operation 5 writes the current PC (the return address) to the effective address, and execution continues at the effective address plus one.
- R7: Operation 6 increments the memory operand, writes it back, and skips the next instruction when the result is zero.
- R8: With bit 15 set on operations 0 to 6, the effective address is the low 12 bits of the word at the address field. This costs exactly one extra cycle: a direct memory instruction takes 3 cycles and an indirect one takes 4.
- R9: Register words 7800 (clear AC), 7400 (clear E), 7200 (invert AC), 7100 (invert E) and 7020 (AC plus one, E untouched) act on AC and E.
- R10: 7080 rotates the 17-bit value {E,AC} right by one bit (E goes to AC bit 15, AC bit 0 goes to E). 7040 rotates it left by one bit (AC bit 15 goes to E, E goes to AC bit 0).
- R11: Skip words add one extra to PC when their condition holds on the old AC and E. The words are 7010 (AC bit 15 clear), 7008 (AC bit 15 set), 7004 (AC zero) and 7002 (E zero).
- R12: 7001 halts the machine. `halted` rises, and PC, AC and E stay unchanged until reset.
- R13: An operation-7 word with bit 15 set (Fxxx) has no effect beyond the normal PC advance.
- R14: Take the program that jumps to 017, loads word 100 (value 0000), skips on zero, loads word 101, increments, stores to 102 and halts. It ends with AC = 0001, and word 102 then holds 0001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pre_we | input | 1 | Preload write strobe |
| pre_addr | input | 12 | Preload word address |
| pre_data | input | 16 | Preload word value |
| halted | output | 1 | Machine stopped by a halt word |
| ac_dbg | output | 16 | Accumulator contents |
| pc_dbg | output | 12 | Program counter |
| e_dbg | output | 1 | Extension flag |

## Verification
A bad decode, a bad effective address or a wrong operand value lands in AC, E or PC. These are visible on the debug outputs once the program halts, usually within the same instruction. A missed or extra skip, or a wrong return address, shifts the final PC by one or more words. A wrong phase sequence changes the number of cycles to halt, so an indirect access that costs other than one extra cycle is seen as a count difference. Stored values are checked by loading them back into AC in a later step or a later run.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;
  localparam int WORD_W  = 16;
  localparam int FIELD_W = 12;
  localparam int OP_W    = 3;
  localparam int IND_BIT = WORD_W - 1;
  localparam int OP_LO   = FIELD_W;

  typedef enum logic [2:0] {
    S_FETCH  = 3'd0,
    S_DECODE = 3'd1,
    S_INDIR  = 3'd2,
    S_EXEC   = 3'd3,
    S_HALT   = 3'd4
  } phase_t;

  localparam logic [OP_W-1:0] OP_AND = 3'd0;
  localparam logic [OP_W-1:0] OP_ADD = 3'd1;
  localparam logic [OP_W-1:0] OP_LDA = 3'd2;
  localparam logic [OP_W-1:0] OP_STA = 3'd3;
  localparam logic [OP_W-1:0] OP_BUN = 3'd4;
  localparam logic [OP_W-1:0] OP_BSA = 3'd5;
  localparam logic [OP_W-1:0] OP_ISZ = 3'd6;
  localparam logic [OP_W-1:0] OP_REG = 3'd7;

  // bit positions inside a register-operation word
  localparam int RB_CLR_A = 11;
  localparam int RB_CLR_E = 10;
  localparam int RB_NOT_A = 9;
  localparam int RB_NOT_E = 8;
  localparam int RB_ROT_R = 7;
  localparam int RB_ROT_L = 6;
  localparam int RB_INC_A = 5;
  localparam int RB_SK_P  = 4;
  localparam int RB_SK_N  = 3;
  localparam int RB_SK_Z  = 2;
  localparam int RB_SK_E  = 1;
  localparam int RB_STOP  = 0;

  typedef struct packed {
    logic [WORD_W-1:0] ac;
    logic              e;
    logic              skip;
    logic              stop;
  } regop_t;

  function automatic logic [WORD_W:0] f_add(input logic [WORD_W-1:0] a,
                                            input logic [WORD_W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  function automatic logic [WORD_W-1:0] f_inc(input logic [WORD_W-1:0] a);
    return a + 1'b1;
  endfunction

  // Register operations: the skip test uses the old AC and E, and the
  // modifications apply in the order clear, invert, rotate, increment.
  function automatic regop_t f_regop(input logic [WORD_W-1:0] ac_in,
                                     input logic              e_in,
                                     input logic [FIELD_W-1:0] sel);
    regop_t r;
    logic [WORD_W-1:0] a;
    logic              x;
    logic              t;
    a = ac_in;
    x = e_in;
    r.skip = (sel[RB_SK_P] && !ac_in[WORD_W-1]) ||
             (sel[RB_SK_N] &&  ac_in[WORD_W-1]) ||
             (sel[RB_SK_Z] && (ac_in == '0))    ||
             (sel[RB_SK_E] && !e_in);
    if (sel[RB_CLR_A]) a = '0;
    if (sel[RB_CLR_E]) x = 1'b0;
    if (sel[RB_NOT_A]) a = ~a;
    if (sel[RB_NOT_E]) x = ~x;
    if (sel[RB_ROT_R]) begin
      t = a[0];
      a = {x, a[WORD_W-1:1]};
      x = t;
    end
    if (sel[RB_ROT_L]) begin
      t = a[WORD_W-1];
      a = {a[WORD_W-2:0], x};
      x = t;
    end
    if (sel[RB_INC_A]) a = f_inc(a);
    r.ac   = a;
    r.e    = x;
    r.stop = sel[RB_STOP];
    return r;
  endfunction
endpackage

// File: rtl/acc_mem.sv
module acc_mem #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              pre_we,
  input  logic [ADDR_W-1:0] pre_addr,
  input  logic [DATA_W-1:0] pre_data,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] words [DEPTH];

  // preload has priority; it is meant for use while the core is in reset
  always_ff @(posedge clk) begin
    if (pre_we)
      words[pre_addr] <= pre_data;
    else if (cpu_we)
      words[cpu_addr] <= cpu_wdata;
  end

  assign rd_data = words[rd_addr];
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_cpu_pkg::*;
(
  input  logic [OP_W-1:0]   op,
  input  logic [WORD_W-1:0] ac_in,
  input  logic              e_in,
  input  logic [WORD_W-1:0] opnd,
  output logic [WORD_W-1:0] ac_out,
  output logic              e_out,
  output logic [WORD_W-1:0] opnd_inc,
  output logic              inc_zero
);
  logic [WORD_W:0] sum;

  always_comb begin
    sum    = f_add(ac_in, opnd);
    ac_out = ac_in;
    e_out  = e_in;
    unique case (op)
      OP_AND: ac_out = ac_in & opnd;
      OP_ADD: begin
        ac_out = sum[WORD_W-1:0];
        e_out  = sum[WORD_W];
      end
      OP_LDA: ac_out = opnd;
      default: ;
    endcase
  end

  assign opnd_inc = f_inc(opnd);
  assign inc_zero = (opnd_inc == '0);
endmodule

// File: rtl/acc_regop.sv
module acc_regop
  import acc_cpu_pkg::*;
(
  input  logic [WORD_W-1:0]  ac_in,
  input  logic               e_in,
  input  logic [FIELD_W-1:0] sel,
  output logic [WORD_W-1:0]  ac_out,
  output logic               e_out,
  output logic               skip,
  output logic               stop
);
  regop_t r;

  always_comb begin
    r      = f_regop(ac_in, e_in, sel);
    ac_out = r.ac;
    e_out  = r.e;
    skip   = r.skip;
    stop   = r.stop;
  end
endmodule

// File: rtl/acc_seq.sv
module acc_seq
  import acc_cpu_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   is_reg,
  input  logic   indirect,
  input  logic   stop_req,
  output phase_t phase
);
  phase_t nxt;

  always_comb begin
    nxt = phase;
    unique case (phase)
      S_FETCH:  nxt = S_DECODE;
      S_DECODE: nxt = (!is_reg && indirect) ? S_INDIR : S_EXEC;
      S_INDIR:  nxt = S_EXEC;
      S_EXEC:   nxt = stop_req ? S_HALT : S_FETCH;
      S_HALT:   nxt = S_HALT;
      default:  nxt = S_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase <= S_FETCH;
    else     phase <= nxt;
  end
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pre_we,
  input  logic [ADDR_W-1:0] pre_addr,
  input  logic [WORD_W-1:0] pre_data,
  output logic              halted,
  output logic [WORD_W-1:0] ac_dbg,
  output logic [ADDR_W-1:0] pc_dbg,
  output logic              e_dbg
);
  logic [ADDR_W-1:0] pc_q, ar_q;
  logic [WORD_W-1:0] ir_q, ac_q;
  logic              e_q;
  phase_t            phase;

  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [WORD_W-1:0] rd_data, wr_data;
  logic              mem_we;

  logic [OP_W-1:0]   op;
  logic              ind_bit, is_reg, is_regop;

  logic [WORD_W-1:0] alu_ac, opnd_inc, rr_ac;
  logic              alu_e, inc_zero, rr_e, rr_skip, rr_stop;

  // named events, brought out for the checker
  logic ev_fetch, ev_indir, ev_exec, ev_skip, ev_bsa, ev_stop;

  assign op       = ir_q[OP_LO +: OP_W];
  assign ind_bit  = ir_q[IND_BIT];
  assign is_reg   = (op == OP_REG);
  assign is_regop = is_reg && !ind_bit;

  assign ev_fetch = (phase == S_FETCH);
  assign ev_indir = (phase == S_INDIR);
  assign ev_exec  = (phase == S_EXEC);
  assign ev_stop  = ev_exec && is_regop && rr_stop;
  assign ev_bsa   = ev_exec && !is_reg && (op == OP_BSA);
  assign ev_skip  = ev_exec && ((is_regop && rr_skip) ||
                                (!is_reg && (op == OP_ISZ) && inc_zero));

  assign rd_addr = ev_fetch ? pc_q : ar_q;
  assign wr_addr = ar_q;

  always_comb begin
    mem_we  = 1'b0;
    wr_data = ac_q;
    if (ev_exec && !is_reg && !rst) begin
      unique case (op)
        OP_STA: mem_we = 1'b1;
        OP_BSA: begin
          mem_we  = 1'b1;
          wr_data = WORD_W'(pc_q);
        end
        OP_ISZ: begin
          mem_we  = 1'b1;
          wr_data = opnd_inc;
        end
        default: ;
      endcase
    end
  end

  acc_mem #(.ADDR_W(ADDR_W), .DATA_W(WORD_W)) u_mem (
    .clk      (clk),
    .pre_we   (pre_we),
    .pre_addr (pre_addr),
    .pre_data (pre_data),
    .cpu_we   (mem_we),
    .cpu_addr (wr_addr),
    .cpu_wdata(wr_data),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data)
  );

  acc_alu u_alu (
    .op      (op),
    .ac_in   (ac_q),
    .e_in    (e_q),
    .opnd    (rd_data),
    .ac_out  (alu_ac),
    .e_out   (alu_e),
    .opnd_inc(opnd_inc),
    .inc_zero(inc_zero)
  );

  acc_regop u_regop (
    .ac_in (ac_q),
    .e_in  (e_q),
    .sel   (ir_q[FIELD_W-1:0]),
    .ac_out(rr_ac),
    .e_out (rr_e),
    .skip  (rr_skip),
    .stop  (rr_stop)
  );

  acc_seq u_seq (
    .clk     (clk),
    .rst     (rst),
    .is_reg  (is_reg),
    .indirect(ind_bit),
    .stop_req(ev_stop),
    .phase   (phase)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= '0;
      ar_q <= '0;
      ir_q <= '0;
      ac_q <= '0;
      e_q  <= 1'b0;
    end else begin
      unique case (phase)
        S_FETCH: begin
          ir_q <= rd_data;
          pc_q <= pc_q + 1'b1;
        end
        S_DECODE: ar_q <= ir_q[ADDR_W-1:0];
        S_INDIR:  ar_q <= rd_data[ADDR_W-1:0];
        S_EXEC: begin
          if (is_reg) begin
            if (!ind_bit) begin
              ac_q <= rr_ac;
              e_q  <= rr_e;
            end
          end else begin
            unique case (op)
              OP_AND, OP_ADD, OP_LDA: begin
                ac_q <= alu_ac;
                e_q  <= alu_e;
              end
              OP_BUN: pc_q <= ar_q;
              OP_BSA: pc_q <= ar_q + 1'b1;
              default: ;
            endcase
          end
          if (ev_skip) pc_q <= pc_q + 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign halted = (phase == S_HALT);
  assign ac_dbg = ac_q;
  assign pc_dbg = pc_q;
  assign e_dbg  = e_q;
endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk #(
  parameter int ADDR_W = 12,
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              halted,
  input logic [ADDR_W-1:0] pc,
  input logic [ADDR_W-1:0] ar,
  input logic [WORD_W-1:0] ac,
  input logic              e,
  input logic              ev_fetch,
  input logic              ev_indir,
  input logic              ev_exec,
  input logic              ev_skip,
  input logic              ev_bsa
);
  // R12
  halt_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted && $stable(pc) && $stable(ac) && $stable(e));

  // R2
  fetch_step_chk: assert property (@(posedge clk) disable iff (rst)
    ev_fetch |=> pc == $past(pc) + 1'b1);

  // R11
  skip_step_chk: assert property (@(posedge clk) disable iff (rst)
    ev_skip |=> pc == $past(pc) + 1'b1);

  // R6
  bsa_target_chk: assert property (@(posedge clk) disable iff (rst)
    ev_bsa |=> pc == $past(ar) + 1'b1);

  // R8
  indir_once_chk: assert property (@(posedge clk) disable iff (rst)
    ev_indir |=> ev_exec);
endmodule

bind acc_cpu acc_cpu_chk #(.ADDR_W(ADDR_W), .WORD_W(16)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .halted  (halted),
  .pc      (pc_q),
  .ar      (ar_q),
  .ac      (ac_q),
  .e       (e_q),
  .ev_fetch(ev_fetch),
  .ev_indir(ev_indir),
  .ev_exec (ev_exec),
  .ev_skip (ev_skip),
  .ev_bsa  (ev_bsa)
);

// File: tb/acc_cpu_test.sv
module acc_cpu_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pre_we = 1'b0;
  logic [11:0] pre_addr = '0;
  logic [15:0] pre_data = '0;
  logic        halted;
  logic [15:0] ac_dbg;
  logic [11:0] pc_dbg;
  logic        e_dbg;

  int n_run = 0;
  int n_fail = 0;
  int cyc;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_cpu uut (
    .clk(clk), .rst(rst), .pre_we(pre_we), .pre_addr(pre_addr),
    .pre_data(pre_data), .halted(halted), .ac_dbg(ac_dbg),
    .pc_dbg(pc_dbg), .e_dbg(e_dbg)
  );

  task automatic expect_eq(input string tag, input logic [31:0] act,
                           input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hold_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
  endtask

  task automatic put(input logic [11:0] a, input logic [15:0] d);
    pre_we = 1'b1; pre_addr = a; pre_data = d;
    @(negedge clk);
    pre_we = 1'b0;
  endtask

  task automatic run_to_halt();
    cyc = 0;
    rst = 1'b0;
    while (!halted && cyc < 3000) begin
      @(negedge clk);
      cyc++;
    end
    expect_eq("R12 halt reached", {31'd0, halted}, 32'd1);
  endtask

  task automatic t_reset();
    hold_reset();
    expect_eq("R1 reset PC", pc_dbg, 0);
    expect_eq("R1 reset AC", ac_dbg, 0);
    expect_eq("R1 reset E", e_dbg, 0);
    expect_eq("R1 reset halted", halted, 0);
  endtask

  task automatic t_demo();
    hold_reset();
    put(12'h000, 16'h4017);
    put(12'h017, 16'h2100); put(12'h018, 16'h7004);
    put(12'h019, 16'h2101); put(12'h01A, 16'h7020);
    put(12'h01B, 16'h3102); put(12'h01C, 16'h7001);
    put(12'h100, 16'h0000); put(12'h101, 16'h000E);
    put(12'h102, 16'h000A);
    run_to_halt();
    expect_eq("R14 demo AC", ac_dbg, 16'h0001);
    expect_eq("R2 demo final PC", pc_dbg, 12'h01D);
    // second run reads back the stored word (R4, R14)
    hold_reset();
    put(12'h000, 16'h2102); put(12'h001, 16'h7001);
    run_to_halt();
    expect_eq("R14 stored word", ac_dbg, 16'h0001);
  endtask

  task automatic t_arith();
    hold_reset();
    put(12'h000, 16'h2010); put(12'h001, 16'h1011); put(12'h002, 16'h7001);
    put(12'h010, 16'hFFFF); put(12'h011, 16'h0002);
    run_to_halt();
    expect_eq("R3 add sum", ac_dbg, 16'h0001);
    expect_eq("R3 add carry", e_dbg, 1);
    hold_reset();
    put(12'h001, 16'h0011);
    put(12'h010, 16'hF0F0); put(12'h011, 16'h0FF0);
    run_to_halt();
    expect_eq("R3 and", ac_dbg, 16'h00F0);
  endtask

  task automatic t_branch();
    hold_reset();
    put(12'h000, 16'h5020); put(12'h001, 16'h7001);
    put(12'h020, 16'h0000); put(12'h021, 16'h2020);
    put(12'h022, 16'h4040); put(12'h040, 16'h7001);
    run_to_halt();
    expect_eq("R6 saved return", ac_dbg, 16'h0001);
    expect_eq("R5 jump target", pc_dbg, 12'h041);
  endtask

  task automatic t_isz();
    hold_reset();
    put(12'h000, 16'h6030); put(12'h001, 16'h4000);
    put(12'h002, 16'h2030); put(12'h003, 16'h7001);
    put(12'h030, 16'hFFFD);
    run_to_halt();
    expect_eq("R7 isz result", ac_dbg, 16'h0000);
    expect_eq("R7 isz exit PC", pc_dbg, 12'h004);
  endtask

  task automatic t_indirect();
    int direct_cyc;
    hold_reset();
    put(12'h000, 16'h2050); put(12'h001, 16'h7001);
    put(12'h050, 16'h1234);
    run_to_halt();
    direct_cyc = cyc;
    expect_eq("R8 direct cycles", direct_cyc, 6);
    hold_reset();
    put(12'h000, 16'hA010); put(12'h010, 16'h0050);
    run_to_halt();
    expect_eq("R8 indirect load", ac_dbg, 16'h1234);
    expect_eq("R8 indirect extra cycle", cyc, direct_cyc + 1);
  endtask

  task automatic t_regops();
    hold_reset();
    put(12'h000, 16'h7800); put(12'h001, 16'h7200);
    put(12'h002, 16'h7100); put(12'h003, 16'h7001);
    run_to_halt();
    expect_eq("R9 invert AC", ac_dbg, 16'hFFFF);
    expect_eq("R9 invert E", e_dbg, 1);
    hold_reset();
    put(12'h000, 16'h7100); put(12'h001, 16'h7400);
    put(12'h002, 16'h7020); put(12'h003, 16'h7001);
    run_to_halt();
    expect_eq("R9 inc AC", ac_dbg, 16'h0001);
    expect_eq("R9 clear E", e_dbg, 0);
  endtask

  task automatic t_rotate();
    hold_reset();
    put(12'h000, 16'h2010); put(12'h001, 16'h7080); put(12'h002, 16'h7001);
    put(12'h010, 16'h8001);
    run_to_halt();
    expect_eq("R10 rotate right AC", ac_dbg, 16'h4000);
    expect_eq("R10 rotate right E", e_dbg, 1);
    hold_reset();
    put(12'h001, 16'h7040);
    run_to_halt();
    expect_eq("R10 rotate left AC", ac_dbg, 16'h0002);
    expect_eq("R10 rotate left E", e_dbg, 1);
  endtask

  task automatic skip_case(input string tag, input logic [15:0] val,
                           input logic [15:0] word, input logic [11:0] exp_pc);
    hold_reset();
    put(12'h000, 16'h2010); put(12'h001, word);
    put(12'h002, 16'h7001); put(12'h003, 16'h7001);
    put(12'h010, val);
    run_to_halt();
    expect_eq(tag, pc_dbg, exp_pc);
  endtask

  task automatic t_skips();
    skip_case("R11 positive taken", 16'h0005, 16'h7010, 12'h004);
    skip_case("R11 negative not taken", 16'h0005, 16'h7008, 12'h003);
    skip_case("R11 negative taken", 16'h8000, 16'h7008, 12'h004);
    skip_case("R11 zero taken", 16'h0000, 16'h7004, 12'h004);
    skip_case("R11 zero not taken", 16'h0001, 16'h7004, 12'h003);
    skip_case("R11 E zero taken", 16'h0001, 16'h7002, 12'h004);
  endtask

  task automatic t_freeze();
    logic [15:0] a0;
    logic [11:0] p0;
    hold_reset();
    put(12'h000, 16'h2010); put(12'h001, 16'h7001); put(12'h010, 16'h0ABC);
    run_to_halt();
    a0 = ac_dbg; p0 = pc_dbg;
    repeat (20) @(negedge clk);
    expect_eq("R12 frozen AC", ac_dbg, a0);
    expect_eq("R12 frozen PC", pc_dbg, p0);
    expect_eq("R12 still halted", halted, 1);
  endtask

  task automatic t_ignored();
    hold_reset();
    put(12'h000, 16'h2010); put(12'h001, 16'hF800);
    put(12'h002, 16'h7001); put(12'h010, 16'h00AA);
    run_to_halt();
    expect_eq("R13 Fxxx leaves AC", ac_dbg, 16'h00AA);
    expect_eq("R13 Fxxx PC advance", pc_dbg, 12'h003);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_demo();
    t_arith();
    t_branch();
    t_isz();
    t_indirect();
    t_regops();
    t_rotate();
    t_skips();
    t_freeze();
    t_ignored();
    t_reset();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule